// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a small processor core that completes one instruction every clock cycle. It covers a minimal slice of a 32-bit three-operand load/store instruction set: register add, register subtract, add-immediate, word load and word store. Each cycle the core presents a byte address to an instruction memory and decodes the word that comes back in the same cycle. It reads two source registers, forms either an arithmetic result or an effective address, and then writes the register file, the data memory, or neither.

The surrounding system supplies two memories with combinational reads. One is an instruction memory indexed by the program counter. The other is a byte-addressed data memory that takes an address, write data and a write strobe, and returns read data in the same cycle. The core has no branches, so a program runs straight through from address zero. Register zero is hard-wired to zero. Because there is no subtract-immediate, subtraction by a constant is done with a negative immediate.

Top module: `rsc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter and all 32 registers are cleared to zero. `imem_addr` reads 0 in the cycle after reset, and `dmem_we` stays low during reset.
- R2: Outside reset, `imem_addr` increases by exactly 4 on every rising edge, whatever instruction was executed.
- R3: An instruction with op[31:26]=0, shamt[10:6]=0 and funct[5:0]=32 writes rs+rt into rd. rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11]. The sum wraps modulo 2^32.
- R4: An instruction with op=0, shamt=0 and funct=34 writes rs−rt into rd, wrapping modulo 2^32.
- R5: op=8 writes rs plus the sign-extended 16-bit field [15:0] into rt. A negative field subtracts, and the field spans −32768 to 32767.
- R6: op=35 drives `dmem_addr` with rs + sign-extended [15:0] and writes `dmem_rdata` into rt.
- R7: op=43 raises `dmem_we` for that one cycle. It drives `dmem_addr` with rs + sign-extended [15:0] and `dmem_wdata` with rt. No other instruction raises `dmem_we`.
- R8: Register 0 always reads as zero, and every write aimed at it is discarded.
- R9: Any other encoding, including op=0 with a non-zero shamt or an unlisted funct, changes no register and no memory. It only advances the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by the memory on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The bench targets the following corner cases; each would show a specific failure:

- **Register 0 writes:** the bench writes register 0 both through add-immediate and through a register add, then stores it. A core that let such a write through would store 14 or 10 instead of 0.
- **Sign extension and wrapping:** a negative immediate, the largest positive immediate, a sum that overflows to zero and a subtraction that goes below zero are all checked. A core that zero-extends the immediate or mishandles wrapping produces the wrong stored values.
- **Near-miss encodings:** the bench issues an add with a non-zero shift amount, an unlisted funct and an unknown opcode, all targeting one register, and then stores that register. A sloppy decoder would have written something there.
- **Store then load:** a load reads back a word that was just stored, which exposes any write-strobe or address error. The program counter is also compared against 4 × cycle on every cycle.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RAW    = $clog2(NREG);
    localparam int IMMW   = 16;
    localparam int OPW    = 6;

    localparam logic [OPW-1:0] OP_RTYPE = 6'd0;
    localparam logic [OPW-1:0] OP_ADDI  = 6'd8;
    localparam logic [OPW-1:0] OP_LW    = 6'd35;
    localparam logic [OPW-1:0] OP_SW    = 6'd43;
    localparam logic [5:0]     FN_ADD   = 6'd32;
    localparam logic [5:0]     FN_SUB   = 6'd34;

    typedef enum logic [2:0] {
        K_NOP, K_ADD, K_SUB, K_ADDI, K_LOAD, K_STORE
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [RAW-1:0]   src_a;
        logic [RAW-1:0]   src_b;
        logic [RAW-1:0]   dst;
        logic             dst_en;
        logic             use_imm;
        logic [XLEN-1:0]  imm;
    } dec_t;
endpackage

// File: rtl/rsc_decode.sv
`timescale 1ns/1ps
module rsc_decode
    import rsc_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output dec_t            dec
);
    logic [OPW-1:0]  op;
    logic [4:0]      sh;
    logic [5:0]      fn;
    logic [RAW-1:0]  f_rs, f_rt, f_rd;

    assign op   = insn[31:26];
    assign f_rs = insn[25:21];
    assign f_rt = insn[20:16];
    assign f_rd = insn[15:11];
    assign sh   = insn[10:6];
    assign fn   = insn[5:0];

    always_comb begin
        dec.kind    = K_NOP;
        dec.src_a   = f_rs;
        dec.src_b   = f_rt;
        dec.dst     = f_rt;
        dec.dst_en  = 1'b0;
        dec.use_imm = 1'b1;
        dec.imm     = {{(XLEN-IMMW){insn[IMMW-1]}}, insn[IMMW-1:0]};
        unique case (op)
            OP_RTYPE: begin
                dec.use_imm = 1'b0;
                dec.dst     = f_rd;
                if (sh == 5'd0 && fn == FN_ADD) begin
                    dec.kind   = K_ADD;
                    dec.dst_en = 1'b1;
                end else if (sh == 5'd0 && fn == FN_SUB) begin
                    dec.kind   = K_SUB;
                    dec.dst_en = 1'b1;
                end
            end
            OP_ADDI: begin
                dec.kind   = K_ADDI;
                dec.dst_en = 1'b1;
            end
            OP_LW: begin
                dec.kind   = K_LOAD;
                dec.dst_en = 1'b1;
            end
            OP_SW: begin
                dec.kind   = K_STORE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rsc_regfile.sv
`timescale 1ns/1ps
module rsc_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [N-1:0][W-1:0] regs_d, regs_q;

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

    always_comb begin
        regs_d = regs_q;
        if (we && wa != '0) regs_d[wa] = wd;
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end
endmodule

// File: rtl/rsc_addsub.sv
`timescale 1ns/1ps
module rsc_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;
    assign b_eff = sub ? ~b : b;
    assign y     = a + b_eff + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/rsc_core.sv
`timescale 1ns/1ps
module rsc_core
    import rsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t          st_d, st_q;
    dec_t            dec;
    logic [XLEN-1:0] va, vb, opnd_b, sum, wb_data;

    rsc_decode u_dec (.insn(imem_data), .dec(dec));

    rsc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (dec.src_a),
        .ra_b (dec.src_b),
        .rd_a (va),
        .rd_b (vb),
        .we   (dec.dst_en & ~rst),
        .wa   (dec.dst),
        .wd   (wb_data)
    );

    assign opnd_b = dec.use_imm ? dec.imm : vb;

    rsc_addsub #(.W(XLEN)) u_alu (
        .a   (va),
        .b   (opnd_b),
        .sub (dec.kind == K_SUB),
        .y   (sum)
    );

    assign wb_data    = (dec.kind == K_LOAD) ? dmem_rdata : sum;
    assign dmem_addr  = sum;
    assign dmem_wdata = vb;
    assign dmem_we    = (dec.kind == K_STORE) & ~rst;
    assign imem_addr  = st_q.pc;

    always_comb begin
        st_d    = st_q;
        st_d.pc = st_q.pc + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/rsc_core_chk.sv
`timescale 1ns/1ps
module rsc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic [31:0] dmem_wdata,
    input logic        dmem_we
);
    // R1: reset drives the fetch address to zero
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> imem_addr == 32'd0);
    // R1: no store while in reset
    a_r1_no_store_in_reset: assert property (@(posedge clk) rst |-> !dmem_we);
    // R2: fetch address steps by 4
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> imem_addr == $past(imem_addr) + 32'd4);
    // R7: only the store opcode raises the write strobe
    a_r7_store_only: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> imem_data[31:26] == 6'd43);
    // R7: a store opcode always raises the strobe
    a_r7_store_strobe: assert property (@(posedge clk) disable iff (rst)
        imem_data[31:26] == 6'd43 |-> dmem_we);
    // R8: storing register zero stores zero
    a_r8_zero_store: assert property (@(posedge clk) disable iff (rst)
        (dmem_we && imem_data[20:16] == 5'd0) |-> dmem_wdata == 32'd0);
endmodule

bind rsc_core rsc_core_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we)
);

// File: tb/rsc_core_tb.sv
`timescale 1ns/1ps
module rsc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    int tests = 0;
    int fails = 0;
    int n     = 0;
    int lw_idx = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    rsc_core dut_i (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic emit(logic [31:0] w);
        imem[n] = w;
        n++;
    endtask

    // driver: place a store in the program and push its expected item
    task automatic emit_store(int rt, int off, logic [31:0] val, string tag);
        exp_t e;
        emit(enc_i(43, 0, rt, off));
        e.a = 32'(off); e.d = val; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pop and compare each store the design makes
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && dmem_we && !done) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected store", dmem_addr, 32'hxxxxxxxx);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " addr"}, dmem_addr, e.a);
                    check({e.tag, " data"}, dmem_wdata, e.d);
                end
            end
        end
    end

    initial begin
        #20000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
        dmem[4] = 32'h8000_0000;

        emit_store(13, 44, 32'd0, "R1 regs cleared");
        emit(enc_i(8, 0, 1, 5));                     // r1 = 5
        emit(enc_i(8, 0, 2, -3));                    // r2 = -3
        emit(enc_r(1, 2, 3, 0, 32));                 // r3 = 2
        emit(enc_r(1, 2, 4, 0, 34));                 // r4 = 8
        emit_store(3, 0, 32'd2, "R3 add");
        emit_store(4, 4, 32'd8, "R4 sub");
        emit_store(2, 8, 32'hFFFF_FFFD, "R5 negative imm");
        emit(enc_i(8, 0, 5, 32767));                 // r5 = 32767
        emit(enc_i(8, 0, 7, 12));                    // r7 = 12
        lw_idx = n;
        emit(enc_i(35, 7, 6, 4));                    // r6 = mem[16]
        emit(enc_r(6, 6, 8, 0, 32));                 // r8 = 0 (wrap)
        emit_store(6, 12, 32'h8000_0000, "R6 load");
        emit_store(8, 20, 32'd0, "R3 wrap");
        emit(enc_r(0, 1, 9, 0, 34));                 // r9 = -5
        emit_store(9, 24, 32'hFFFF_FFFB, "R4 wrap");
        emit(enc_i(8, 1, 0, 9));                     // r0 write attempt
        emit(enc_r(1, 1, 0, 0, 32));                 // r0 write attempt
        emit_store(0, 28, 32'd0, "R8 zero reg");
        emit(enc_r(1, 1, 10, 1, 32));                // shamt != 0 -> no-op
        emit(enc_r(1, 1, 10, 0, 33));                // unlisted funct
        emit(enc_i(2, 1, 10, 77));                   // unknown opcode
        emit_store(10, 32, 32'd0, "R9 no-op");
        emit(enc_i(8, 5, 11, 1));                    // r11 = 32768
        emit_store(11, 36, 32'd32768, "R5 max imm");
        emit(enc_i(35, 0, 12, 0));                   // r12 = mem[0]
        emit_store(12, 40, 32'd2, "R7 store then R6 load");

        repeat (3) @(negedge clk);
        #1;
        check("R1 reset pc", imem_addr, 32'd0);
        check("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 40; i++) begin
            #1;
            check("R2 pc step", imem_addr, 32'(4 * i));
            if (i == lw_idx) check("R6 load address", dmem_addr, 32'd16);
            @(negedge clk);
        end
        done = 1;
        check("R7 all stores seen", 32'(exp_q.size()), 32'd0);
        check("R7 memory word", dmem[10], 32'd2);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule